// File: doc/BRIEF.md
# Sequential Nonce-Sweep Double Hash Engine

This block sweeps a run of consecutive 32-bit nonces through a double SHA-256 of an 80-byte header. It uses a single round datapath and a single 16-word message-schedule window, and it shares them in time across every compression of every nonce. A start pulse launches a sweep. The block hashes the first 64-byte chunk of the header once and keeps the resulting chaining state. For each nonce it then performs two compressions. The first covers the second chunk, which carries the nonce and the padding. The second rehashes the 256-bit intermediate digest from the standard initial values.

The header is supplied as twenty big-endian 32-bit words, with word j on `header_i[j]`. Word 19 gives the first nonce of the sweep. Entry i of the result array holds the first word of the final digest for nonce `header_i[19] + i`. `done_o` pulses when the last entry has been written. One compression occupies 66 cycles: a load cycle, 64 round cycles and a feed-forward cycle. A sweep of 16 nonces therefore takes 2178 cycles.

Top module: `nonce_sweep_hash`

## Requirements
- R1: After reset `done_o` is low and every entry of `digest_o` is zero.
- R2: Entry i of `digest_o` equals word 0 of SHA-256(SHA-256(H)). H is the 80-byte header, taken as big-endian words with word j equal to `header_i[j]` for j < 19 and word 19 replaced by the nonce of entry i.
- R3: The nonce of entry i is `header_i[19] + i` modulo 2^32. It is placed as word 3 of the second 64-byte chunk. That chunk is padded with word 0x80000000, ten zero words and a bit-length word of 640.
- R4: `done_o` is high for exactly one cycle. While the block is idle, `digest_o` does not change.
- R5: `done_o` is high in the cycle after the 66*(2*NUM_NONCES+1)-th rising edge that follows the edge accepting `start_i`. The first chunk is compressed only once per sweep.
- R6: `start_i` asserted while a sweep is running has no effect on timing or results.
- R7: A start after `done_o` runs a fresh sweep and overwrites every entry with results for the new header.
- R8: The block gives correct results and timing with NUM_NONCES set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sweep when idle |
| header_i | input | 20x32 | Header words; word 19 is the first nonce |
| digest_o | output | NUM_NONCESx32 | Word 0 of the final digest, one entry per nonce |
| done_o | output | 1 | One-cycle pulse at the end of a sweep |

## Verification
The bench builds two copies of the block that run side by side: one with the default of 16 nonces and one with a single nonce. With 16 nonces the nonce index walks through every value, and a base of 0xFFFFFFF8 makes the nonce wrap past zero inside a sweep. With a single nonce the path that fills the last entry runs straight after the first one, and the shortest sweep length is checked. Every entry is compared with a behavioural double SHA-256 written in the bench, and the cycle of `done_o` is compared with the formula from R5.

// File: rtl/nsh_pkg.sv
package nsh_pkg;
  localparam logic [3:0] ST_IDLE    = 4'b0000;
  localparam logic [3:0] ST_PREP    = 4'b0001;
  localparam logic [3:0] ST_COMPUTE = 4'b0010;
  localparam logic [3:0] ST_FINAL   = 4'b0011;
  localparam logic [3:0] ST_DONE    = 4'b0100;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned BLK_WRDS = 16;
  localparam int unsigned ROUNDS   = 64;
  localparam int unsigned HDR_WRDS = 20;

  localparam logic [255:0] SHA_IV = {
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  localparam logic [2047:0] K_TAB = {
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  function automatic logic [31:0] rotr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [31:0] round_k(input logic [5:0] t);
    return K_TAB[(63 - int'(t)) * 32 +: 32];
  endfunction

  function automatic logic [31:0] sig0(input logic [31:0] x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] sig1(input logic [31:0] x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic logic [255:0] sha_round(input logic [255:0] s,
                                             input logic [31:0] w,
                                             input logic [31:0] k);
    logic [31:0] a, b, c, d, e, f, g, h, big0, big1, ch, mj, t1, t2;
    {a, b, c, d, e, f, g, h} = s;
    big1 = rotr(e, 6) ^ rotr(e, 11) ^ rotr(e, 25);
    ch   = (e & f) ^ (~e & g);
    t1   = h + big1 + ch + k + w;
    big0 = rotr(a, 2) ^ rotr(a, 13) ^ rotr(a, 22);
    mj   = (a & b) ^ (a & c) ^ (b & c);
    t2   = big0 + mj;
    return {t1 + t2, a, b, c, d + t1, e, f, g};
  endfunction

  // word-wise feed-forward add of two 8-word states
  function automatic logic [255:0] add8(input logic [255:0] x, input logic [255:0] y);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = x[i*32 +: 32] + y[i*32 +: 32];
    return r;
  endfunction
endpackage

// File: rtl/nsh_msg_sched.sv
module nsh_msg_sched
  import nsh_pkg::*;
(
  input  logic                           clk_i,
  input  logic [3:0]                     state_i,
  input  logic [BLK_WRDS-1:0][WORD_W-1:0] blk_i,
  output logic [WORD_W-1:0]              w_o
);
  logic [WORD_W-1:0] win [BLK_WRDS];
  logic [WORD_W-1:0] w_next;

  // window holds W[t..t+15]; the round always consumes slot 0
  assign w_next = sig1(win[BLK_WRDS-2]) + win[BLK_WRDS-7] + sig0(win[1]) + win[0];
  assign w_o    = win[0];

  always_ff @(posedge clk_i) begin
    case (state_i)
      ST_PREP: begin
        for (int i = 0; i < BLK_WRDS; i++) win[i] <= blk_i[i];
      end
      ST_COMPUTE: begin
        for (int i = 0; i < BLK_WRDS-1; i++) win[i] <= win[i+1];
        win[BLK_WRDS-1] <= w_next;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/nsh_round_core.sv
module nsh_round_core
  import nsh_pkg::*;
(
  input  logic              clk_i,
  input  logic [3:0]        state_i,
  input  logic              chain_i,
  input  logic [255:0]      mid_i,
  input  logic [WORD_W-1:0] w_i,
  input  logic [WORD_W-1:0] k_i,
  output logic [255:0]      st_o
);
  // working registers a..h: driven only by state, no reset
  always_ff @(posedge clk_i) begin
    case (state_i)
      ST_PREP:    st_o <= chain_i ? mid_i : SHA_IV;
      ST_COMPUTE: st_o <= sha_round(st_o, w_i, k_i);
      default:    st_o <= st_o;
    endcase
  end
endmodule

// File: rtl/nonce_sweep_hash.sv
module nonce_sweep_hash
  import nsh_pkg::*;
#(
  parameter int unsigned NUM_NONCES = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic [HDR_WRDS-1:0][WORD_W-1:0]    header_i,
  output logic [NUM_NONCES-1:0][WORD_W-1:0]  digest_o,
  output logic                               done_o
);
  localparam int unsigned IDX_W = (NUM_NONCES > 1) ? $clog2(NUM_NONCES) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_NONCES - 1);
  localparam logic [5:0] RND_LAST = 6'(ROUNDS - 1);
  localparam logic [1:0] PH_HEAD = 2'd0, PH_NONCE = 2'd1, PH_REHASH = 2'd2;

  logic [3:0]       state;
  logic [1:0]       phase;
  logic [5:0]       rnd;
  logic [IDX_W-1:0] idx;
  logic [255:0]     mid_q, dig1_q, st;
  logic [NUM_NONCES-1:0][WORD_W-1:0] digest_q;
  logic [BLK_WRDS-1:0][WORD_W-1:0]   blk;
  logic [WORD_W-1:0] w_cur, nonce;

  assign nonce    = header_i[HDR_WRDS-1] + WORD_W'(idx);
  assign digest_o = digest_q;
  assign done_o   = (state == ST_DONE);

  // block presented to the schedule window in PREP
  always_comb begin
    blk = '0;
    case (phase)
      PH_HEAD: for (int j = 0; j < BLK_WRDS; j++) blk[j] = header_i[j];
      PH_NONCE: begin
        for (int j = 0; j < 3; j++) blk[j] = header_i[BLK_WRDS + j];
        blk[3]  = nonce;
        blk[4]  = 32'h8000_0000;
        blk[15] = 32'd640;
      end
      default: begin
        for (int j = 0; j < 8; j++) blk[j] = dig1_q[255 - 32*j -: 32];
        blk[8]  = 32'h8000_0000;
        blk[15] = 32'd256;
      end
    endcase
  end

  nsh_msg_sched u_sched (
    .clk_i   (clk_i),
    .state_i (state),
    .blk_i   (blk),
    .w_o     (w_cur)
  );

  nsh_round_core u_core (
    .clk_i   (clk_i),
    .state_i (state),
    .chain_i (phase == PH_NONCE),
    .mid_i   (mid_q),
    .w_i     (w_cur),
    .k_i     (round_k(rnd)),
    .st_o    (st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      phase    <= PH_HEAD;
      rnd      <= '0;
      idx      <= '0;
      mid_q    <= '0;
      dig1_q   <= '0;
      digest_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          state <= ST_PREP;
          phase <= PH_HEAD;
          idx   <= '0;
        end
        ST_PREP: begin
          state <= ST_COMPUTE;
          rnd   <= '0;
        end
        ST_COMPUTE: begin
          rnd <= rnd + 6'd1;
          if (rnd == RND_LAST) state <= ST_FINAL;
        end
        ST_FINAL: begin
          state <= ST_PREP;
          case (phase)
            PH_HEAD: begin
              mid_q <= add8(SHA_IV, st);
              phase <= PH_NONCE;
            end
            PH_NONCE: begin
              dig1_q <= add8(mid_q, st);
              phase  <= PH_REHASH;
            end
            default: begin
              digest_q[idx] <= SHA_IV[255:224] + st[255:224];
              phase <= PH_NONCE;
              if (idx == IDX_LAST) state <= ST_DONE;
              else                 idx   <= idx + 1'b1;
            end
          endcase
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |=> $stable(digest_o));

  p_compute_exit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_COMPUTE) |=> (state == ST_COMPUTE || state == ST_FINAL));

  p_busy_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && state == ST_COMPUTE) |=> ($stable(phase) && $stable(idx)));

  p_final_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FINAL) |=> $stable(st));

  p_done_after_rehash_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(state) == ST_FINAL && $past(phase) == PH_REHASH));
endmodule

// File: tb/nonce_sweep_hash_tb_top.sv
module nonce_sweep_hash_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start16 = 1'b0, start1 = 1'b0;
  logic [19:0][31:0] hdr = '0;
  logic [15:0][31:0] d16;
  logic [0:0][31:0]  d1;
  logic done16, done1;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  nonce_sweep_hash #(.NUM_NONCES(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start16), .header_i(hdr),
    .digest_o(d16), .done_o(done16));

  nonce_sweep_hash #(.NUM_NONCES(1)) dut_n1_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start1), .header_i(hdr),
    .digest_o(d1), .done_o(done1));

  logic [31:0] kt [64] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5, 32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3, 32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc, 32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7, 32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13, 32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3, 32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5, 32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208, 32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2};

  localparam logic [255:0] IV = {32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
                                 32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19};

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    return (x >> n) | (x << (32 - n));
  endfunction

  function automatic logic [255:0] ref_comp(input logic [255:0] s0, input logic [31:0] m [16]);
    logic [31:0] w [64];
    logic [31:0] v [8];
    logic [31:0] t1, t2;
    logic [255:0] r;
    for (int i = 0; i < 16; i++) w[i] = m[i];
    for (int i = 16; i < 64; i++)
      w[i] = (rr(w[i-2],17) ^ rr(w[i-2],19) ^ (w[i-2] >> 10)) + w[i-7]
           + (rr(w[i-15],7) ^ rr(w[i-15],18) ^ (w[i-15] >> 3)) + w[i-16];
    for (int i = 0; i < 8; i++) v[i] = s0[255 - 32*i -: 32];
    for (int i = 0; i < 64; i++) begin
      t1 = v[7] + (rr(v[4],6) ^ rr(v[4],11) ^ rr(v[4],25)) + ((v[4] & v[5]) ^ (~v[4] & v[6])) + kt[i] + w[i];
      t2 = (rr(v[0],2) ^ rr(v[0],13) ^ rr(v[0],22)) + ((v[0] & v[1]) ^ (v[0] & v[2]) ^ (v[1] & v[2]));
      v[7] = v[6]; v[6] = v[5]; v[5] = v[4]; v[4] = v[3] + t1;
      v[3] = v[2]; v[2] = v[1]; v[1] = v[0]; v[0] = t1 + t2;
    end
    for (int i = 0; i < 8; i++) r[255 - 32*i -: 32] = s0[255 - 32*i -: 32] + v[i];
    return r;
  endfunction

  function automatic logic [31:0] ref_hash(input logic [19:0][31:0] h, input logic [31:0] nonce);
    logic [31:0] m [16];
    logic [255:0] s1, s2, s3;
    for (int i = 0; i < 16; i++) m[i] = h[i];
    s1 = ref_comp(IV, m);
    for (int i = 0; i < 16; i++) m[i] = 32'h0;
    m[0] = h[16]; m[1] = h[17]; m[2] = h[18]; m[3] = nonce;
    m[4] = 32'h8000_0000; m[15] = 32'd640;
    s2 = ref_comp(s1, m);
    for (int i = 0; i < 16; i++) m[i] = 32'h0;
    for (int i = 0; i < 8; i++) m[i] = s2[255 - 32*i -: 32];
    m[8] = 32'h8000_0000; m[15] = 32'd256;
    s3 = ref_comp(IV, m);
    return s3[255:224];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic check_results(input string req);
    logic [31:0] e;
    for (int i = 0; i < 16; i++) begin
      e = ref_hash(hdr, hdr[19] + 32'(i));
      chk(d16[i] == e, req, d16[i], e);
    end
    e = ref_hash(hdr, hdr[19]);
    chk(d1[0] == e, {req, " R8 n1"}, d1[0], e);
  endtask

  // R1: reset state
  task automatic t_reset();
    chk(done16 == 1'b0, "R1 done16", 32'(done16), 0);
    chk(done1 == 1'b0, "R1 done1", 32'(done1), 0);
    for (int i = 0; i < 16; i++) chk(d16[i] == 0, "R1 digest", d16[i], 0);
    chk(d1[0] == 0, "R1 digest n1", d1[0], 0);
  endtask

  // runs both copies; poke asserts start16 mid-run (R6); checks R5, R4 pulse, R2/R3
  task automatic t_sweep(input logic [19:0][31:0] h, input bit poke, input string req);
    int cyc, got16, got1;
    bit seen16, seen1;
    hdr = h;
    @(negedge clk); start16 = 1'b1; start1 = 1'b1;
    @(posedge clk);
    @(negedge clk); start16 = 1'b0; start1 = 1'b0;
    cyc = 1; seen16 = 0; seen1 = 0; got16 = 0; got1 = 0;
    while (!(seen16 && seen1 && cyc > got16 + 1 && cyc > got1 + 1) && cyc < 5000) begin
      if (done16 && !seen16) begin seen16 = 1; got16 = cyc; end
      if (done1 && !seen1) begin seen1 = 1; got1 = cyc; end
      if (seen16 && cyc == got16 + 1) chk(!done16, "R4 pulse16", 32'(done16), 0);
      if (seen1 && cyc == got1 + 1)   chk(!done1, "R4 pulse1", 32'(done1), 0);
      start16 = (poke && cyc == 300);
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    start16 = 1'b0;
    chk(got16 == 66*33 + 1, {req, " R5 cycles16"}, 32'(got16), 66*33 + 1);
    chk(got1 == 66*3 + 1, {req, " R5 R8 cycles1"}, 32'(got1), 66*3 + 1);
    check_results({req, " R2 R3"});
  endtask

  // R4: outputs hold while idle
  task automatic t_hold();
    logic [15:0][31:0] snap;
    snap = d16;
    repeat (25) @(negedge clk);
    for (int i = 0; i < 16; i++) chk(d16[i] == snap[i], "R4 hold", d16[i], snap[i]);
  endtask

  logic [19:0][31:0] ha, hb;

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) ha[i] = 32'h1234_5678 * 32'(i + 1) ^ 32'h0bad_f00d;
    ha[19] = 32'h0000_0100;
    t_sweep(ha, 1'b0, "R2");
    t_hold();
    hb = ha;
    hb[19] = 32'hffff_fff8;  // R3 nonce wraps past zero
    t_sweep(hb, 1'b1, "R6");
    for (int i = 0; i < 20; i++) hb[i] = {16'(i * 7 + 3), 16'hc0de} ^ 32'(i << 20);
    t_sweep(hb, 1'b0, "R7");
    t_hold();
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end
endmodule